// File: doc/BRIEF.md
# DRAM Refresh Cycle Sequencer

This block drives the control strobes of an asynchronous 16-bit-wide DRAM through refresh cycles. It handles two refresh types with one set of phase timers. In row-addressed refresh, a row address is put on the bus and RAS is pulsed while both CAS lanes stay high. In CAS-first refresh, both CAS lanes fall ahead of RAS and the device uses its internal row counter, so the address bus is not driven. The write strobe is held high for the whole cycle in both types, so the sequence also suits parts that decode WE at the RAS edge.

A request pulse `refresh_req` starts a cycle. `refresh_mode` chooses the type (0 = row-addressed, 1 = CAS-first), and `row_in` gives the row. Every minimum and maximum interval is a nanosecond parameter. Each one is turned into clock cycles by ceiling division by `CLK_PERIOD_NS`. The state machine steps through IDLE → SETUP → RAS_LOW → PRECHARGE → DONE. DONE returns to IDLE, or goes straight to SETUP when a request is waiting. A request that arrives while a cycle runs is held in a one-entry latch, together with its mode and row.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_lo_n`, `cas_hi_n` and `we_n` are high, while `addr_oe` and `refresh_done` are low.
- R2: SETUP lasts S = max(1, ⌈tASR⌉, ⌈tCSR⌉, ⌈tWRP⌉, ⌈tCRP⌉) cycles, so RAS falls S cycles after the cycle starts. RAS then stays low for exactly L = max(⌈tRASmin⌉, ⌈tRC⌉−S−P−1, ⌈tRAH⌉, ⌈tCHR⌉, ⌈tWRH⌉) cycles. L never exceeds ⌊tRASmax/period⌋; a violating parameter set is rejected at elaboration.
- R3: In row-addressed mode (`refresh_mode`=0), both CAS lanes stay high for the whole cycle. `addr_oe` is high, and `addr` equals the row, from the start of SETUP until RAS rises.
- R4: The row is captured when the request is accepted. Later changes on `row_in` do not alter `addr` during that cycle.
- R5: In CAS-first mode (`refresh_mode`=1), both CAS lanes go low at the start of SETUP and stay low until RAS rises. `addr_oe` stays low for the whole cycle.
- R6: `we_n` is high at every cycle of every refresh, including the cycles around each RAS edge.
- R7: After RAS rises, it stays high for at least P = max(⌈tRP⌉, ⌈tCP⌉, ⌈tRPC⌉) cycles. Back-to-back cycles put P+1+S cycles between a RAS rise and the next RAS fall.
- R8: Both CAS lanes are high during PRECHARGE and DONE. Between two CAS-first cycles, CAS stays high for P+1 cycles, which is at least ⌈tCP⌉.
- R9: `refresh_done` is a one-cycle pulse that is asserted P cycles after RAS rises.
- R10: A request that arrives while a cycle is busy is served directly after DONE, using the mode and row present when it arrived. A further request that arrives while one is already waiting is dropped. A request seen during DONE starts the next SETUP at once.
- R11: The mode and row are sampled together with the request that starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_req | input | 1 | Refresh request, one cycle per request |
| refresh_mode | input | 1 | 0 = row-addressed refresh, 1 = CAS-first refresh |
| row_in | input | ROW_W | Row to refresh in row-addressed mode |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe, active low |
| cas_hi_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ROW_W | Address bus |
| addr_oe | output | 1 | Address bus drive enable |
| refresh_done | output | 1 | One-cycle pulse at the end of each cycle |

## Verification
The bench records every strobe cycle by cycle and measures each edge-to-edge interval against counts it derives itself. A phase timer loaded one cycle off would move the RAS fall or shorten the RAS low time and break tRAS or tRC. Changing the row input mid-cycle catches a design that drives `addr` straight from `row_in` instead of from its capture. Requests placed mid-cycle, a third request while one is waiting, and a request in the DONE cycle expose a latch that loses requests, serves stale modes or rows, serves a dropped request, or stalls through an extra IDLE cycle. Two CAS-first cycles back to back check that CAS goes high between them for the precharge time.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SETUP     = 3'd1,
        ST_RAS_LOW   = 3'd2,
        ST_PRECHARGE = 3'd3,
        ST_DONE      = 3'd4
    } drfsh_state_e;

    typedef enum logic {
        MODE_ROW_ADDR  = 1'b0,
        MODE_CAS_FIRST = 1'b1
    } drfsh_mode_e;

    // Ceiling conversion of a nanosecond limit to clock cycles
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drfsh_phase_timer.sv
module drfsh_phase_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/drfsh_req_latch.sv
module drfsh_req_latch #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             set_mode,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clear,
    output logic             pend,
    output logic             pend_mode,
    output logic [ROW_W-1:0] pend_row
);

    logic             pend_q;
    logic             mode_q;
    logic [ROW_W-1:0] row_q;

    // A new request may be stored when the slot is free or emptied this cycle
    logic store;
    assign store = set && (!pend_q || clear);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            mode_q <= 1'b0;
            row_q  <= '0;
        end else begin
            if (store) begin
                pend_q <= 1'b1;
                mode_q <= set_mode;
                row_q  <= set_row;
            end else if (clear) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend      = pend_q;
    assign pend_mode = mode_q;
    assign pend_row  = row_q;

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clear) |=> (pend_q && $stable(row_q) && $stable(mode_q)));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drfsh_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int ROW_W         = 10,
    parameter int T_RAS_MIN_NS  = 60,
    parameter int T_RAS_MAX_NS  = 10000,
    parameter int T_RP_NS       = 40,
    parameter int T_RC_NS       = 105,
    parameter int T_ASR_NS      = 0,
    parameter int T_RAH_NS      = 10,
    parameter int T_CSR_NS      = 10,
    parameter int T_CHR_NS      = 10,
    parameter int T_CP_NS       = 10,
    parameter int T_CRP_NS      = 5,
    parameter int T_RPC_NS      = 5,
    parameter int T_WRP_NS      = 10,
    parameter int T_WRH_NS      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_req,
    input  logic             refresh_mode,
    input  logic [ROW_W-1:0] row_in,
    output logic             ras_n,
    output logic             cas_lo_n,
    output logic             cas_hi_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr,
    output logic             addr_oe,
    output logic             refresh_done
);

    // ---------------------------------------------------------------
    // Derived cycle counts
    // ---------------------------------------------------------------
    localparam int SETUP_CYC = imax(imax(1, ns_to_cyc(T_ASR_NS, CLK_PERIOD_NS)),
                                    imax(imax(ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_WRP_NS, CLK_PERIOD_NS)),
                                         ns_to_cyc(T_CRP_NS, CLK_PERIOD_NS)));
    localparam int PRE_CYC   = imax(imax(1, ns_to_cyc(T_RP_NS, CLK_PERIOD_NS)),
                                    imax(ns_to_cyc(T_CP_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_RPC_NS, CLK_PERIOD_NS)));
    localparam int RAS_MIN_CYC = ns_to_cyc(T_RAS_MIN_NS, CLK_PERIOD_NS);
    localparam int RAS_MAX_CYC = T_RAS_MAX_NS / CLK_PERIOD_NS;
    localparam int RC_FILL_CYC = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - SETUP_CYC - PRE_CYC - 1;
    localparam int RAS_LOW_CYC = imax(imax(imax(1, RAS_MIN_CYC), RC_FILL_CYC),
                                      imax(imax(ns_to_cyc(T_RAH_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_CHR_NS, CLK_PERIOD_NS)),
                                           ns_to_cyc(T_WRH_NS, CLK_PERIOD_NS)));
    localparam int LONGEST_CYC = imax(imax(SETUP_CYC, RAS_LOW_CYC), PRE_CYC);
    localparam int TMR_W       = $clog2(LONGEST_CYC + 1);
    localparam int LOW_W       = $clog2(RAS_MAX_CYC + 2);
    localparam int HI_W        = $clog2(PRE_CYC + 2);

    localparam logic [TMR_W-1:0] SETUP_LOAD = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] LOW_LOAD   = TMR_W'(RAS_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] PRE_LOAD   = TMR_W'(PRE_CYC - 1);

    // R2: reject a parameter set whose RAS low phase breaks its own maximum
    generate
        if (RAS_LOW_CYC > RAS_MAX_CYC) begin : g_ras_window_bad
            $error("RAS low phase of %0d cycles exceeds the maximum of %0d", RAS_LOW_CYC, RAS_MAX_CYC);
        end
    endgenerate

    // ---------------------------------------------------------------
    // State and cycle context
    // ---------------------------------------------------------------
    drfsh_state_e     state_q, state_d;
    drfsh_mode_e      cur_mode_q;
    logic [ROW_W-1:0] cur_row_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    logic             pend;
    logic             pend_mode;
    logic [ROW_W-1:0] pend_row;

    logic can_launch;
    logic launch;
    logic take_direct;
    logic latch_set;
    logic latch_clear;

    assign can_launch  = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign launch      = can_launch && (pend || refresh_req);
    assign take_direct = can_launch && !pend && refresh_req;
    assign latch_set   = refresh_req && !take_direct;
    assign latch_clear = launch && pend;

    drfsh_req_latch #(
        .ROW_W (ROW_W)
    ) u_req_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (latch_set),
        .set_mode  (refresh_mode),
        .set_row   (row_in),
        .clear     (latch_clear),
        .pend      (pend),
        .pend_mode (pend_mode),
        .pend_row  (pend_row)
    );

    drfsh_phase_timer #(
        .WIDTH (TMR_W)
    ) u_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (launch)      state_d = ST_SETUP;
            ST_SETUP:     if (tmr_expired) state_d = ST_RAS_LOW;
            ST_RAS_LOW:   if (tmr_expired) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (tmr_expired) state_d = ST_DONE;
            ST_DONE:      state_d = launch ? ST_SETUP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:     tmr_val = SETUP_LOAD;
            ST_RAS_LOW:   tmr_val = LOW_LOAD;
            ST_PRECHARGE: tmr_val = PRE_LOAD;
            default:      tmr_val = '0;
        endcase
    end

    // State register and cycle context capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_mode_q <= MODE_ROW_ADDR;
            cur_row_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                cur_mode_q <= drfsh_mode_e'(pend ? pend_mode : refresh_mode);
                cur_row_q  <= pend ? pend_row : row_in;
            end
        end
    end

    // Strobe decode
    always_comb begin
        logic front;
        front        = (state_q == ST_SETUP) || (state_q == ST_RAS_LOW);
        ras_n        = (state_q != ST_RAS_LOW);
        cas_lo_n     = !(front && (cur_mode_q == MODE_CAS_FIRST));
        cas_hi_n     = !(front && (cur_mode_q == MODE_CAS_FIRST));
        addr_oe      = front && (cur_mode_q == MODE_ROW_ADDR);
        addr         = addr_oe ? cur_row_q : '0;
        we_n         = 1'b1;
        refresh_done = (state_q == ST_DONE);
    end

    // ---------------------------------------------------------------
    // Interval monitors for the assertions
    // ---------------------------------------------------------------
    logic [LOW_W-1:0] low_run_q;
    logic [HI_W-1:0]  high_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= HI_W'(PRE_CYC + 1);
        end else begin
            if (ras_n) begin
                low_run_q <= '0;
                if (high_run_q < HI_W'(PRE_CYC + 1)) high_run_q <= high_run_q + 1'b1;
            end else begin
                high_run_q <= '0;
                if (low_run_q < LOW_W'(RAS_MAX_CYC + 1)) low_run_q <= low_run_q + 1'b1;
            end
        end
    end

    // R2
    ras_low_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= LOW_W'(RAS_MAX_CYC));

    // R2
    ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run_q >= LOW_W'(RAS_MIN_CYC)));

    // R7
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_run_q >= HI_W'(PRE_CYC)));

    // R3
    row_addr_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && addr_oe) |-> (cas_lo_n && cas_hi_n && $past(addr_oe) && $stable(addr)));

    // R5
    cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !addr_oe) |-> (!cas_lo_n && !cas_hi_n && $past(!cas_lo_n && !cas_hi_n)));

    // R6
    we_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) || $rose(ras_n)) |-> (we_n && $past(we_n)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_done |=> !refresh_done);

    // R9
    done_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_done |-> (ras_n && cas_lo_n && cas_hi_n));

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

    localparam int CLK_NS = 8;
    localparam int RW     = 10;
    localparam int NS     = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_req = 1'b0;
    logic          refresh_mode = 1'b0;
    logic [RW-1:0] row_in = '0;
    logic          ras_n, cas_lo_n, cas_hi_n, we_n, addr_oe, refresh_done;
    logic [RW-1:0] addr;

    int checks = 0;
    int errors = 0;

    int e_setup, e_pre, e_low, e_rc, e_cp, e_ras_min, e_ras_max;

    // recorded samples and injected stimulus
    logic          s_ras [NS];
    logic          s_cl  [NS];
    logic          s_ch  [NS];
    logic          s_we  [NS];
    logic          s_oe  [NS];
    logic          s_done[NS];
    logic [RW-1:0] s_addr[NS];
    logic          inj_req [NS];
    logic          inj_set [NS];
    logic          inj_mode[NS];
    logic [RW-1:0] inj_row [NS];

    always #(CLK_NS / 2) clk = ~clk;

    dram_refresh_seq i_dram_refresh_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_req  (refresh_req),
        .refresh_mode (refresh_mode),
        .row_in       (row_in),
        .ras_n        (ras_n),
        .cas_lo_n     (cas_lo_n),
        .cas_hi_n     (cas_hi_n),
        .we_n         (we_n),
        .addr         (addr),
        .addr_oe      (addr_oe),
        .refresh_done (refresh_done)
    );

    function automatic int cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_inj();
        for (int i = 0; i < NS; i++) begin
            inj_req[i] = 1'b0; inj_set[i] = 1'b0; inj_mode[i] = 1'b0; inj_row[i] = '0;
        end
    endtask

    // Called right after a negedge; drives the first request, then samples n cycles
    task automatic capture(input logic mode, input logic [RW-1:0] row, input int n);
        refresh_req = 1'b1; refresh_mode = mode; row_in = row;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_ras[i] = ras_n; s_cl[i] = cas_lo_n; s_ch[i] = cas_hi_n; s_we[i] = we_n;
            s_oe[i] = addr_oe; s_done[i] = refresh_done; s_addr[i] = addr;
            refresh_req = inj_req[i];
            if (inj_set[i]) begin
                refresh_mode = inj_mode[i];
                row_in = inj_row[i];
            end
        end
        refresh_req = 1'b0;
        clear_inj();
    endtask

    function automatic int find_ras(input logic v, input int from, input int n);
        if (from < 0) return -1;
        for (int i = from; i < n; i++) if (s_ras[i] == v) return i;
        return -1;
    endfunction

    function automatic int find_done(input int from, input int n);
        if (from < 0) return -1;
        for (int i = from; i < n; i++) if (s_done[i]) return i;
        return -1;
    endfunction

    // Measures one refresh cycle that starts (SETUP) at sample index start
    task automatic check_cycle(input int start, input logic mode, input logic [RW-1:0] row,
                               input int n, output int r_out, output int d_out);
        int f, r, d, bad_front, bad_we, bad_pre;
        f = find_ras(1'b0, start, n);
        r = find_ras(1'b1, f, n);
        d = find_done(r, n);
        r_out = r; d_out = d;
        if (f < 0 || r < 0 || d < 0 || d + 1 >= n) begin
            chk(1'b0, "R2 cycle edges present", f, start + e_setup);
            return;
        end
        chk(f - start == e_setup, "R2 setup before RAS fall", f - start, e_setup);
        chk(r - f == e_low, "R2 RAS low width", r - f, e_low);
        chk(r - f >= e_ras_min && r - f <= e_ras_max, "R2 RAS low within min/max", r - f, e_ras_min);
        chk(d - r == e_pre, "R9 done after precharge", d - r, e_pre);
        chk(!s_done[d + 1] && !s_done[d - 1], "R9 done one cycle", int'(s_done[d + 1]), 0);
        bad_front = 0; bad_we = 0; bad_pre = 0;
        for (int i = start; i < r; i++) begin
            if (mode == 1'b0) begin
                if (!s_cl[i] || !s_ch[i] || !s_oe[i] || s_addr[i] != row) bad_front++;
            end else begin
                if (s_cl[i] || s_ch[i] || s_oe[i]) bad_front++;
            end
        end
        for (int i = start; i <= d; i++) if (!s_we[i]) bad_we++;
        for (int i = r; i <= d; i++) if (!s_cl[i] || !s_ch[i] || s_oe[i]) bad_pre++;
        if (mode == 1'b0) chk(bad_front == 0, "R3 row-addressed strobes/address", bad_front, 0);
        else              chk(bad_front == 0, "R5 CAS-first strobes, address idle", bad_front, 0);
        chk(bad_we == 0, "R6 WE high through cycle", bad_we, 0);
        chk(bad_pre == 0, "R8 CAS high in precharge", bad_pre, 0);
    endtask

    task automatic t_reset();
        chk({ras_n, cas_lo_n, cas_hi_n, we_n, addr_oe, refresh_done} == 6'b111100,
            "R1 reset outputs", {ras_n, cas_lo_n, cas_hi_n, we_n, addr_oe, refresh_done}, 6'b111100);
    endtask

    task automatic t_row_addr();
        int r, d, extra;
        capture(1'b0, 10'h2A5, 30);
        check_cycle(0, 1'b0, 10'h2A5, 30, r, d);
        extra = 0;
        for (int i = d + 1; i < 30; i++) if (!s_ras[i]) extra++;
        chk(extra == 0, "R11 single request gives single cycle", extra, 0);
    endtask

    task automatic t_cas_first();
        int r, d;
        capture(1'b1, 10'h155, 30);
        check_cycle(0, 1'b1, 10'h155, 30, r, d);
    endtask

    task automatic t_row_change();
        int r, d, bad;
        for (int i = 0; i < 12; i++) begin
            inj_set[i] = 1'b1; inj_mode[i] = 1'b0; inj_row[i] = RW'(i * 37 + 1);
        end
        capture(1'b0, 10'h0F0, 30);
        check_cycle(0, 1'b0, 10'h0F0, 30, r, d);
        bad = 0;
        for (int i = 0; i < r; i++) if (s_addr[i] != 10'h0F0) bad++;
        chk(bad == 0, "R4 row held despite row_in changes", bad, 0);
    endtask

    task automatic t_back_to_back();
        int r1, d1, r2, d2, f2, extra;
        inj_req[4] = 1'b1; inj_set[4] = 1'b1; inj_mode[4] = 1'b0; inj_row[4] = 10'h3C3;
        inj_req[6] = 1'b1; inj_set[6] = 1'b1; inj_mode[6] = 1'b1; inj_row[6] = 10'h111;
        inj_set[7] = 1'b1; inj_mode[7] = 1'b1; inj_row[7] = 10'h222;
        capture(1'b1, 10'h000, 60);
        check_cycle(0, 1'b1, 10'h000, 60, r1, d1);
        check_cycle(d1 + 1, 1'b0, 10'h3C3, 60, r2, d2);
        f2 = find_ras(1'b0, r1, 60);
        chk(f2 - r1 == e_pre + 1 + e_setup, "R7 RAS high gap back to back", f2 - r1, e_pre + 1 + e_setup);
        chk(f2 - find_ras(1'b0, 0, 60) >= e_rc, "R7 RAS fall to fall >= tRC", f2, e_rc);
        extra = 0;
        for (int i = d2 + 1; i < 60; i++) if (!s_ras[i]) extra++;
        chk(extra == 0, "R10 request while pending dropped", extra, 0);
    endtask

    task automatic t_cas_pair();
        int r1, d1, r2, d2, gap;
        inj_req[3] = 1'b1; inj_set[3] = 1'b1; inj_mode[3] = 1'b1; inj_row[3] = 10'h000;
        capture(1'b1, 10'h000, 50);
        check_cycle(0, 1'b1, 10'h000, 50, r1, d1);
        check_cycle(d1 + 1, 1'b1, 10'h000, 50, r2, d2);
        gap = 0;
        for (int i = r1; i < 50 && s_cl[i] && s_ch[i]; i++) gap++;
        chk(gap == e_pre + 1 && gap >= e_cp, "R8 CAS precharge between CAS-first cycles", gap, e_pre + 1);
    endtask

    task automatic t_req_at_done();
        int r1, d1, r2, d2, at;
        at = e_setup + e_low + e_pre;
        inj_req[at] = 1'b1; inj_set[at] = 1'b1; inj_mode[at] = 1'b1; inj_row[at] = 10'h0AA;
        capture(1'b0, 10'h001, 45);
        check_cycle(0, 1'b0, 10'h001, 45, r1, d1);
        chk(d1 == at, "R10 done index", d1, at);
        check_cycle(d1 + 1, 1'b1, 10'h0AA, 45, r2, d2);
        chk(r2 > 0 && d2 == at + 1 + e_setup + e_low + e_pre, "R10 request in DONE starts next cycle at once",
            d2, at + 1 + e_setup + e_low + e_pre);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        e_setup   = mx(mx(1, cyc(0)), mx(mx(cyc(10), cyc(10)), cyc(5)));
        e_pre     = mx(mx(1, cyc(40)), mx(cyc(10), cyc(5)));
        e_rc      = cyc(105);
        e_cp      = cyc(10);
        e_ras_min = cyc(60);
        e_ras_max = 10000 / CLK_NS;
        e_low     = mx(mx(e_ras_min, e_rc - e_setup - e_pre - 1), mx(cyc(10), cyc(10)));
        clear_inj();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_row_addr();
        t_cas_first();
        t_row_change();
        t_back_to_back();
        t_cas_pair();
        t_req_at_done();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule